// File: doc/BRIEF.md
# Spread Carrier Symbol Sequencer

This block turns one outgoing message into a timed stream of symbol commands for an external chirp generator. For every clock it states whether a chirp should be playing and which of the two opposite chirp phases to use. It also drives the enable of the external output amplifier. A message has three phases. The first is a preamble built from the first character with on/off keying, where each symbol is a full chirp slot followed by a short quiet gap. The second is a fixed run of alternating-phase sync symbols. The third is a body that sends the first character again and then any further host bits, using phase-reversal keying.

The host starts a message with a one-cycle request and presents the first character alongside it. Further bits are offered on a data/valid pair. The sequencer takes one such bit at each body symbol boundary and acknowledges it with a one-cycle pulse. When no bit is offered at a boundary, the message ends. A contention-lost flag from the receiver stops transmission at once.

Top module: `chirp_symbol_seq`

## Requirements
- R1: When idle, and in the cycle after reset, `amp_en`, `chirp_on`, `phase_sel` and `bit_take` are all 0. Whenever `amp_en` is 0, `chirp_on`, `phase_sel` and `bit_take` are 0.
- R2: The preamble is CHAR_W symbols of SYM_CLKS+GAP_CLKS clocks (default 1200+168), one per bit of the first character, least significant bit first. A 1 bit gives `chirp_on`=1 for the first SYM_CLKS clocks of its symbol and 0 for the rest. A 0 bit gives `chirp_on`=0 for the whole symbol. `phase_sel` is 0 throughout.
- R3: The sync phase is SYNC_SYMS symbols of SYM_CLKS clocks with `chirp_on`=1. `phase_sel` is 0 on the first sync symbol and alternates on each symbol after it.
- R4: The body first resends the first character, least significant bit first, as CHAR_W symbols of SYM_CLKS clocks with `chirp_on`=1. A 1 bit is sent with `phase_sel`=0 and a 0 bit with `phase_sel`=1.
- R5: At each symbol boundary after the resent character, if `bit_valid` is 1, `bit_data` is taken and sent as the next body symbol under the R4 phase rule. `bit_take` is 1 for exactly one cycle, in the last output cycle of the symbol before it.
- R6: If `bit_valid` is 0 at such a boundary, the message ends and all outputs are 0 from the next cycle.
- R7: `start_req` is sampled at a clock edge. The first preamble clock appears on the outputs after the following edge. `amp_en` stays 1 from then until the message ends.
- R8: When `lost` is sampled 1 during a message, all outputs are 0 after that same edge. The block stays idle until the next `start_req`.
- R9: `start_req` has no effect while a message is in progress. `lost` has no effect while idle.
- R10: Reset is synchronous and active high, and it returns the block to idle from any phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 12 MHz symbol clock |
| rst | input | 1 | Synchronous reset, active high |
| start_req | input | 1 | One-cycle request to begin a message |
| first_char | input | CHAR_W | First character, captured with `start_req` |
| bit_valid | input | 1 | A further host bit is offered |
| bit_data | input | 1 | The offered host bit (1 = mark) |
| lost | input | 1 | Contention lost, from the receiver |
| bit_take | output | 1 | One-cycle acknowledge of a taken host bit |
| chirp_on | output | 1 | Chirp generator active |
| phase_sel | output | 1 | Chirp phase: 0 first phase, 1 inverted phase |
| amp_en | output | 1 | External amplifier drive enable; 0 puts it in high impedance |

## Verification
The assertions check cycle-level invariants on every cycle. No chirp, phase or take may appear while the amplifier is off. A lost flag always silences the outputs on the next cycle. A take pulse only occurs during an active body chirp. The amplifier only turns on two ticks after a start request. The exact symbol lengths, the bit order, the quiet gap in the preamble, the sync alternation, the end-of-message rule and the ignoring of a repeated start can only be shown by the bench. It compares every output cycle of whole messages against a model of the requirements.

// File: rtl/chirp_seq_pkg.sv
package chirp_seq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_PRE  = 2'd1,
    PH_SYNC = 2'd2,
    PH_BODY = 2'd3
  } phase_e;
endpackage

// File: rtl/chirp_sym_timer.sv
// Counts clocks within a symbol; long symbols add a quiet gap after the chirp slot.
module chirp_sym_timer #(
  parameter int SYM_CLKS = 1200,
  parameter int GAP_CLKS = 168,
  localparam int LONG_CLKS = SYM_CLKS + GAP_CLKS,
  localparam int CNT_W = $clog2(LONG_CLKS)
) (
  input  logic clk,
  input  logic rst,
  input  logic hold_zero,
  input  logic long_sym,
  output logic sym_last,
  output logic in_chirp
);
  logic [CNT_W-1:0] cnt;

  always_comb begin
    if (long_sym) sym_last = (cnt == CNT_W'(LONG_CLKS - 1));
    else          sym_last = (cnt == CNT_W'(SYM_CLKS - 1));
    in_chirp = (cnt < CNT_W'(SYM_CLKS));
  end

  always_ff @(posedge clk) begin
    if (rst || hold_zero || sym_last) cnt <= '0;
    else                              cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/chirp_bit_select.sv
// Holds the first character and the latest host bit; picks the bit for the current symbol.
module chirp_bit_select #(
  parameter int CHAR_W = 8,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_char,
  input  logic [CHAR_W-1:0] char_in,
  input  logic              load_host,
  input  logic              host_in,
  input  logic [IDX_W-1:0]  idx,
  output logic              cur_bit
);
  logic [CHAR_W-1:0] char_q;
  logic              host_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      char_q <= '0;
      host_q <= 1'b0;
    end else begin
      if (load_char) char_q <= char_in;
      if (load_host) host_q <= host_in;
    end
  end

  always_comb begin
    cur_bit = host_q;
    for (int i = 0; i < CHAR_W; i++) begin
      if (idx == IDX_W'(i)) cur_bit = char_q[i];
    end
  end
endmodule

// File: rtl/chirp_symbol_seq.sv
module chirp_symbol_seq #(
  parameter int CHAR_W    = 8,
  parameter int SYNC_SYMS = 4,
  parameter int SYM_CLKS  = 1200,
  parameter int GAP_CLKS  = 168,
  localparam int MAX_IDX = (CHAR_W > SYNC_SYMS) ? CHAR_W : SYNC_SYMS,
  localparam int IDX_W   = $clog2(MAX_IDX + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_req,
  input  logic [CHAR_W-1:0] first_char,
  input  logic              bit_valid,
  input  logic              bit_data,
  input  logic              lost,
  output logic              bit_take,
  output logic              chirp_on,
  output logic              phase_sel,
  output logic              amp_en
);
  import chirp_seq_pkg::*;

  phase_e           ph;
  logic [IDX_W-1:0] idx;
  logic             sym_last, in_chirp, cur_bit;
  logic             accept, take_now;

  assign accept   = (ph == PH_IDLE) && start_req;
  assign take_now = (ph == PH_BODY) && !lost && sym_last &&
                    (idx >= IDX_W'(CHAR_W - 1)) && bit_valid;

  chirp_sym_timer #(.SYM_CLKS(SYM_CLKS), .GAP_CLKS(GAP_CLKS)) u_timer (
    .clk(clk), .rst(rst),
    .hold_zero((ph == PH_IDLE) || lost),
    .long_sym(ph == PH_PRE),
    .sym_last(sym_last), .in_chirp(in_chirp)
  );

  chirp_bit_select #(.CHAR_W(CHAR_W), .IDX_W(IDX_W)) u_bits (
    .clk(clk), .rst(rst),
    .load_char(accept), .char_in(first_char),
    .load_host(take_now), .host_in(bit_data),
    .idx(idx), .cur_bit(cur_bit)
  );

  // phase sequencing
  always_ff @(posedge clk) begin
    if (rst) begin
      ph  <= PH_IDLE;
      idx <= '0;
    end else if (ph == PH_IDLE) begin
      if (start_req) begin
        ph  <= PH_PRE;
        idx <= '0;
      end
    end else if (lost) begin
      ph  <= PH_IDLE;
      idx <= '0;
    end else if (sym_last) begin
      unique case (ph)
        PH_PRE: begin
          if (idx == IDX_W'(CHAR_W - 1)) begin
            ph  <= PH_SYNC;
            idx <= '0;
          end else idx <= idx + 1'b1;
        end
        PH_SYNC: begin
          if (idx == IDX_W'(SYNC_SYMS - 1)) begin
            ph  <= PH_BODY;
            idx <= '0;
          end else idx <= idx + 1'b1;
        end
        PH_BODY: begin
          if (idx < IDX_W'(CHAR_W - 1)) idx <= idx + 1'b1;
          else if (bit_valid)           idx <= IDX_W'(CHAR_W);
          else begin
            ph  <= PH_IDLE;
            idx <= '0;
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  // registered symbol commands
  always_ff @(posedge clk) begin
    if (rst) begin
      amp_en    <= 1'b0;
      chirp_on  <= 1'b0;
      phase_sel <= 1'b0;
      bit_take  <= 1'b0;
    end else begin
      amp_en   <= (ph != PH_IDLE) && !lost;
      bit_take <= take_now;
      unique case (ph)
        PH_PRE: begin
          chirp_on  <= cur_bit && in_chirp && !lost;
          phase_sel <= 1'b0;
        end
        PH_SYNC: begin
          chirp_on  <= !lost;
          phase_sel <= idx[0] && !lost;
        end
        PH_BODY: begin
          chirp_on  <= !lost;
          phase_sel <= !cur_bit && !lost;
        end
        default: begin
          chirp_on  <= 1'b0;
          phase_sel <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/chirp_symbol_seq_chk.sv
module chirp_symbol_seq_chk #(
  parameter int CHAR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              start_req,
  input logic [CHAR_W-1:0] first_char,
  input logic              bit_valid,
  input logic              bit_data,
  input logic              lost,
  input logic              bit_take,
  input logic              chirp_on,
  input logic              phase_sel,
  input logic              amp_en
);
  a_r1_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
    !amp_en |-> (!chirp_on && !phase_sel && !bit_take));

  a_r8_lost_silences: assert property (@(posedge clk) disable iff (rst)
    lost |=> (!amp_en && !chirp_on));

  a_r5_take_in_body: assert property (@(posedge clk) disable iff (rst)
    bit_take |-> (amp_en && chirp_on));

  a_r3_phase_needs_chirp: assert property (@(posedge clk) disable iff (rst)
    phase_sel |-> chirp_on);

  a_r7_amp_after_start: assert property (@(posedge clk) disable iff (rst)
    $rose(amp_en) |-> $past(start_req, 2));
endmodule

bind chirp_symbol_seq chirp_symbol_seq_chk #(.CHAR_W(CHAR_W)) u_chk (.*);

// File: tb/chirp_symbol_seq_tb.sv
module chirp_symbol_seq_tb;
  localparam int CW   = 8;
  localparam int NSY  = 4;
  localparam int SYM  = 1200;
  localparam int GAP  = 168;
  localparam int LONG = SYM + GAP;
  localparam int PRE_TOT = CW * LONG;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_req = 1'b0;
  logic [CW-1:0] first_char = '0;
  logic bit_valid = 1'b0;
  logic bit_data = 1'b0;
  logic lost = 1'b0;
  logic bit_take, chirp_on, phase_sel, amp_en;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  chirp_symbol_seq #(.CHAR_W(CW), .SYNC_SYMS(NSY), .SYM_CLKS(SYM), .GAP_CLKS(GAP)) u_dut (
    .clk(clk), .rst(rst), .start_req(start_req), .first_char(first_char),
    .bit_valid(bit_valid), .bit_data(bit_data), .lost(lost),
    .bit_take(bit_take), .chirp_on(chirp_on), .phase_sel(phase_sel), .amp_en(amp_en)
  );

  // expected {amp_en, chirp_on, phase_sel, bit_take} at message clock k
  function automatic logic [3:0] exp_out(int k, logic [CW-1:0] ch, int n, logic [3:0] bits);
    logic b;
    logic tk;
    int k2, s, bi;
    tk = 1'b0;
    k2 = k + 1 - PRE_TOT;
    if (k2 > 0 && (k2 % SYM) == 0) begin
      bi = k2 / SYM - NSY;
      if (bi >= CW && bi < CW + n) tk = 1'b1;
    end
    if (k < PRE_TOT) begin
      s = k / LONG;
      return {1'b1, ch[s] && ((k % LONG) < SYM), 1'b0, tk};
    end
    s = (k - PRE_TOT) / SYM;
    if (s < NSY) return {1'b1, 1'b1, 1'(s % 2), tk};
    bi = s - NSY;
    if (bi < CW) b = ch[bi];
    else if (bi < CW + n) b = bits[bi - CW];
    else return 4'b0000;
    return {1'b1, 1'b1, ~b, tk};
  endfunction

  function automatic string tag_of(int k, int n, int lost_at);
    int s;
    if (lost_at >= 0 && k > lost_at) return "R8";
    if (k < 0) return "R7";
    if (k < PRE_TOT) return "R2";
    s = (k - PRE_TOT) / SYM;
    if (s < NSY) return "R3";
    if (s < NSY + CW) return "R4";
    if (s < NSY + CW + n) return "R5";
    return "R6";
  endfunction

  task automatic check(string req, logic [3:0] act, logic [3:0] exp_v, int k);
    n_chk++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s at k=%0d: actual amp/chirp/phase/take=%b expected %b", req, k, act, exp_v);
    end
  endtask

  task automatic run_msg(logic [CW-1:0] ch, int n, logic [3:0] bits, int lost_at, int dup_at);
    int total, last_k, ti;
    logic [3:0] e;
    total  = CW * LONG + (NSY + CW + n) * SYM;
    last_k = (lost_at >= 0) ? lost_at + 3 : total + 2;
    ti = 0;
    @(negedge clk);
    start_req  = 1'b1;
    first_char = ch;
    bit_valid  = (n > 0);
    bit_data   = bits[0];
    @(negedge clk);
    start_req = 1'b0;
    check("R7", {amp_en, chirp_on, phase_sel, bit_take}, 4'b0000, -1);
    @(negedge clk);
    for (int k = 0; k <= last_k; k++) begin
      e = exp_out(k, ch, n, bits);
      if (lost_at >= 0 && k > lost_at) e = 4'b0000;
      check(tag_of(k, n, lost_at), {amp_en, chirp_on, phase_sel, bit_take}, e, k);
      if (bit_take) begin
        ti++;
        if (ti < n) bit_data = bits[ti];
        else bit_valid = 1'b0;
      end
      lost = (k == lost_at);
      start_req = (k == dup_at);   // R9: repeated start while busy
      @(negedge clk);
    end
    lost = 1'b0;
    start_req = 1'b0;
    bit_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [CW-1:0] rc;
    logic [3:0] rb;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", {amp_en, chirp_on, phase_sel, bit_take}, 4'b0000, -1);
    // R9: lost while idle does nothing
    lost = 1'b1; @(negedge clk); lost = 1'b0; @(negedge clk);
    check("R9", {amp_en, chirp_on, phase_sel, bit_take}, 4'b0000, -1);

    run_msg(8'hA5, 2, 4'b0010, -1, -1);
    run_msg(8'h00, 0, 4'b0000, -1, -1);
    run_msg(8'hFF, 3, 4'b0101, -1, 5000);
    rc = CW'($urandom); rb = 4'($urandom);
    run_msg(rc, 3, rb, PRE_TOT + 9 * SYM + 37, -1);
    rc = CW'($urandom) | 8'h01; rb = 4'($urandom);
    run_msg(rc, 1, rb, 700 + int'($urandom % 500), -1);

    // R10: reset in the middle of a message
    @(negedge clk);
    start_req = 1'b1; first_char = 8'h3C; bit_valid = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
    repeat (6000) @(negedge clk);
    check("R10", {amp_en, 3'b000}, 4'b1000, -1);
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    check("R10", {amp_en, chirp_on, phase_sel, bit_take}, 4'b0000, -1);
    repeat (1500) @(negedge clk);
    check("R10", {amp_en, chirp_on, phase_sel, bit_take}, 4'b0000, -1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule